// File: doc/BRIEF.md
# Serial EEPROM Command Engine

This block is the command engine of a 512-byte serial EEPROM that a host reaches over SPI in mode 0 or mode 3. The SPI pins are brought into the system clock domain, and each edge is found there. A bit on the data input is taken on each rising serial clock. The data output moves on each falling serial clock, and every byte goes most significant bit first. The first byte of a selection is the instruction. Array reads and array writes then take an address byte, and the ninth address bit rides in bit 3 of the instruction.

Reads stream bytes from consecutive addresses for as long as the host keeps clocking. Writes collect 1 to 16 bytes of one page in a page buffer. The buffer goes to the array only when chip select rises cleanly after a whole data byte. A busy interval then runs for a parameterised number of clock cycles. In the first cycles of that interval, the buffer is walked one entry at a time. Each filled entry is offered to an external protection unit, and an entry is written only when that unit grants it. The watchdog and lock fields of the status byte are driven out to neighbouring logic.

Top module: `spi_eeprom_engine`

## Requirements
- R1: After reset, a status read returns 0x30, wdog_sel is 2'b11 and lock_sel is 2'b00. so_oe is low whenever chip select is high. If chip select is already low when reset is released, the block ignores all clocking until chip select has gone high and then low again.
- R2: Instruction 0x06 sets the write-enable bit and instruction 0x04 clears it. The write-enable bit is status bit 1.
- R3: When the write-enable bit is clear, an array write instruction (0000_A010) or a status write instruction (0x01) leaves the array and the status unchanged.
- R4: Instruction 0000_A011, followed by an address byte, reads from address {A, address byte}. Each further byte comes from the next address, and the address wraps from 0x1FF to 0x000.
- R5: An array write stores its data bytes at consecutive offsets within one 16-byte page. When the offset passes 15 it wraps to 0, and a later byte overwrites an earlier one at the same offset.
- R6: A write is committed only if chip select rises after a whole number of data bytes (at least one). If chip select rises at any other point, the write is dropped.
- R7: During the busy interval of BUSY_CYCLES clocks, status reads (0x05) still work and status bit 0 reads 1. At the end of the interval, the write-enable bit is cleared.
- R8: While busy, every instruction other than the status read is ignored. An array write sent then has no effect.
- R9: A buffered byte whose address the protection unit refuses (chk_ok low while chk_valid) is not written. Other bytes of the same page are still written.
- R10: A committed status write (0x01 and then a data byte) loads data bits 5:4 into the watchdog field and data bits 3:2 into the lock field. Status read format: {2'b00, watchdog[1:0], lock[1:0], write-enable, busy}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sck | input | 1 | SPI serial clock |
| cs_n | input | 1 | SPI chip select, active low |
| si | input | 1 | Serial data into the block |
| so | output | 1 | Serial data out of the block |
| so_oe | output | 1 | Output enable for so; low means high impedance |
| chk_valid | output | 1 | A buffered byte is offered for commit |
| chk_addr | output | 9 | Array address of the offered byte |
| chk_ok | input | 1 | Protection unit grants the write |
| wdog_sel | output | 2 | Watchdog period field |
| lock_sel | output | 2 | Block lock field |
| busy | output | 1 | Internal write cycle in progress |

## Verification
The assertions rely on the SPI pins changing slowly compared with clk. Each level must last at least three clock cycles, so that the synchroniser sees every edge and no serial clock edge falls on the same cycle as a chip-select edge. They also expect chk_ok to be settled in any cycle where chk_valid is high. The bench holds each serial-clock half period at six clocks. It changes si only while the serial clock is low, and moves chip select only after the serial clock has been low for a full half period. The protection model is combinational on chk_addr, so chk_ok is ready in the same cycle the address is offered.

// File: rtl/spi_eeprom_engine.sv
module spi_eeprom_engine #(
  parameter int PAGE_W      = 4,
  parameter int BUSY_CYCLES = 250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       si,
  output logic       so,
  output logic       so_oe,
  output logic       chk_valid,
  output logic [8:0] chk_addr,
  input  logic       chk_ok,
  output logic [1:0] wdog_sel,
  output logic [1:0] lock_sel,
  output logic       busy
);
  localparam int AW       = 9;
  localparam int DEPTH    = 1 << AW;
  localparam int PLEN     = 1 << PAGE_W;
  localparam int BUSY_N   = (BUSY_CYCLES > PLEN) ? BUSY_CYCLES : PLEN + 1;
  localparam int CNT_W    = $clog2(BUSY_N + 1);
  localparam logic [1:0] WD_RST = 2'b11;
  localparam logic [1:0] BL_RST = 2'b00;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_RADR, S_RDAT, S_RDSR, S_WADR, S_WDAT, S_WSR, S_IGN
  } st_t;

  logic [2:0] s_sck, s_cs;
  logic [1:0] s_si;
  logic sck_r, sck_f, cs_f, cs_r, sel, si_b;

  st_t        st;
  logic       armed;
  logic [6:0] sh;
  logic [2:0] bitc;
  logic       a8;
  logic [AW-1:0] addr;
  logic       ld;
  logic [7:0] nxt, osr, byte_in, status;
  logic [7:0] pbuf [PLEN];
  logic [PLEN-1:0] pval;
  logic [AW-PAGE_W-1:0] page;
  logic [PAGE_W-1:0] off;
  logic       have;
  logic [3:0] sr_pend;
  logic       wel, wip, kind;
  logic [CNT_W-1:0] bcnt;
  logic [PAGE_W:0] walk;
  logic [1:0] wd, bl;
  logic       mem_we;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s_sck <= '0;
      s_cs  <= '0;
      s_si  <= '0;
    end else begin
      s_sck <= {s_sck[1:0], sck};
      s_cs  <= {s_cs[1:0], cs_n};
      s_si  <= {s_si[0], si};
    end

  assign sck_r   = s_sck[1] & ~s_sck[2];
  assign sck_f   = ~s_sck[1] & s_sck[2];
  assign cs_f    = ~s_cs[1] & s_cs[2];
  assign cs_r    = s_cs[1] & ~s_cs[2];
  assign sel     = armed & ~s_cs[1];
  assign si_b    = s_si[1];
  assign byte_in = {sh, si_b};
  assign status  = {2'b00, wd, bl, wel, wip};

  assign so_oe     = sel;
  assign so        = sel & osr[7];
  assign busy      = wip;
  assign wdog_sel  = wd;
  assign lock_sel  = bl;
  assign chk_valid = wip & ~kind & ~walk[PAGE_W] & pval[walk[PAGE_W-1:0]];
  assign chk_addr  = {page, walk[PAGE_W-1:0]};
  assign mem_we    = chk_valid & chk_ok;

  always_ff @(posedge clk)
    if (mem_we) mem[chk_addr] <= pbuf[walk[PAGE_W-1:0]];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      armed   <= 1'b0;
      sh      <= '0;
      bitc    <= '0;
      a8      <= 1'b0;
      addr    <= '0;
      ld      <= 1'b0;
      nxt     <= '0;
      osr     <= '0;
      pval    <= '0;
      page    <= '0;
      off     <= '0;
      have    <= 1'b0;
      sr_pend <= '0;
      wel     <= 1'b0;
      wip     <= 1'b0;
      kind    <= 1'b0;
      bcnt    <= '0;
      walk    <= '0;
      wd      <= WD_RST;
      bl      <= BL_RST;
      for (int i = 0; i < PLEN; i++) pbuf[i] <= '0;
    end else begin
      if (wip) begin
        if (!walk[PAGE_W]) walk <= walk + 1'b1;
        if (bcnt == '0) begin
          wip <= 1'b0;
          wel <= 1'b0;
          if (kind) {wd, bl} <= sr_pend;
        end else begin
          bcnt <= bcnt - 1'b1;
        end
      end

      if (cs_f) begin
        armed <= 1'b1;
        st    <= S_CMD;
        bitc  <= '0;
        ld    <= 1'b0;
        have  <= 1'b0;
      end else if (cs_r) begin
        if (armed && !wip && have && bitc == '0 && (st == S_WDAT || st == S_WSR)) begin
          wip  <= 1'b1;
          kind <= (st == S_WSR);
          bcnt <= CNT_W'(BUSY_N - 1);
          walk <= '0;
        end
        st   <= S_IDLE;
        have <= 1'b0;
      end else if (sel && sck_f) begin
        if (ld) begin
          osr <= nxt;
          ld  <= 1'b0;
        end else begin
          osr <= {osr[6:0], 1'b0};
        end
      end else if (sel && sck_r) begin
        sh   <= {sh[5:0], si_b};
        bitc <= bitc + 1'b1;
        if (bitc == 3'd7) begin
          unique case (st)
            S_CMD: begin
              if (wip && byte_in != 8'h05) st <= S_IGN;
              else if (byte_in == 8'h06) begin wel <= 1'b1; st <= S_IGN; end
              else if (byte_in == 8'h04) begin wel <= 1'b0; st <= S_IGN; end
              else if (byte_in == 8'h05) begin nxt <= status; ld <= 1'b1; st <= S_RDSR; end
              else if (byte_in == 8'h01) st <= wel ? S_WSR : S_IGN;
              else if (byte_in[7:4] == 4'h0 && byte_in[2:0] == 3'b011) begin
                a8 <= byte_in[3];
                st <= S_RADR;
              end else if (byte_in[7:4] == 4'h0 && byte_in[2:0] == 3'b010) begin
                a8 <= byte_in[3];
                st <= wel ? S_WADR : S_IGN;
              end else st <= S_IGN;
            end
            S_RADR: begin
              nxt  <= mem[{a8, byte_in}];
              addr <= {a8, byte_in} + 1'b1;
              ld   <= 1'b1;
              st   <= S_RDAT;
            end
            S_RDAT: begin
              nxt  <= mem[addr];
              addr <= addr + 1'b1;
              ld   <= 1'b1;
            end
            S_RDSR: begin
              nxt <= status;
              ld  <= 1'b1;
            end
            S_WADR: begin
              page <= {a8, byte_in[7:PAGE_W]};
              off  <= byte_in[PAGE_W-1:0];
              pval <= '0;
              st   <= S_WDAT;
            end
            S_WDAT: begin
              pbuf[off] <= byte_in;
              pval[off] <= 1'b1;
              off       <= off + 1'b1;
              have      <= 1'b1;
            end
            S_WSR: begin
              sr_pend <= byte_in[5:2];
              have    <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end

  p_wel_before_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(wel));

  p_wel_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel);

  p_busy_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> (st == S_IDLE || st == S_CMD || st == S_RDSR || st == S_IGN));

  p_write_granted_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (chk_ok && wip));

  p_quiet_deselected_r1: assert property (@(posedge clk) disable iff (!rst_n)
    s_cs[1] |-> !so_oe && !so);

  p_lock_stable_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wip) |-> $stable(lock_sel) && $stable(wdog_sel));
endmodule

// File: tb/tb_spi_eeprom_engine.sv
module tb_spi_eeprom_engine;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b0, si = 1'b0;
  logic so, so_oe, chk_valid, chk_ok, busy;
  logic [8:0] chk_addr;
  logic [1:0] wdog_sel, lock_sel;
  logic prot_on = 1'b0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign chk_ok = !(prot_on && chk_addr >= 9'h1E8 && chk_addr <= 9'h1EF);

  spi_eeprom_engine #(.PAGE_W(4), .BUSY_CYCLES(400)) dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .so(so), .so_oe(so_oe), .chk_valid(chk_valid), .chk_addr(chk_addr),
    .chk_ok(chk_ok), .wdog_sel(wdog_sel), .lock_sel(lock_sel), .busy(busy));

  localparam logic [16:0] VEC [6] = '{
    {9'h000, 8'hA5}, {9'h1FF, 8'h3C}, {9'h123, 8'h5A},
    {9'h023, 8'hC3}, {9'h0F0, 8'h11}, {9'h1E9, 8'h77}};

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      si = b[i];
      waitc(H);
      sck = 1'b1;
      r[i] = so;
      waitc(H);
      sck = 1'b0;
    end
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    waitc(H);
  endtask

  task automatic cs_hi();
    waitc(H);
    cs_n = 1'b1;
    waitc(2 * H);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    cs_lo();
    xfer(op, r);
    cs_hi();
  endtask

  task automatic rd_status(output logic [7:0] s);
    logic [7:0] r;
    cs_lo();
    xfer(8'h05, r);
    xfer(8'h00, s);
    cs_hi();
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int k = 0; k < 40; k++) begin
      rd_status(s);
      if (!s[0]) break;
    end
  endtask

  task automatic wr_seq(input logic [8:0] a, input int n, input logic [7:0] d0, input int extra);
    logic [7:0] r;
    cs_lo();
    xfer({4'h0, a[8], 3'b010}, r);
    xfer(a[7:0], r);
    for (int i = 0; i < n; i++) xfer(d0 + 8'(i), r);
    for (int i = 0; i < extra; i++) begin
      si = 1'b1;
      waitc(H);
      sck = 1'b1;
      waitc(H);
      sck = 1'b0;
    end
    cs_hi();
  endtask

  task automatic rd_open(input logic [8:0] a);
    logic [7:0] r;
    cs_lo();
    xfer({4'h0, a[8], 3'b011}, r);
    xfer(a[7:0], r);
  endtask

  task automatic rd1(input logic [8:0] a, output logic [7:0] d);
    rd_open(a);
    xfer(8'h00, d);
    cs_hi();
  endtask

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, d;
    waitc(10);
    rst_n = 1'b1;
    waitc(10);
    chk("R1 so_oe without fresh select", {7'b0, so_oe}, 8'h00);
    xfer(8'h06, d);
    cs_hi();
    chk("R1 so_oe with cs high", {7'b0, so_oe}, 8'h00);
    rd_status(s);
    chk("R1 status after reset, no stray enable", s, 8'h30);
    chk("R1 wdog_sel reset", {6'b0, wdog_sel}, 8'h03);
    chk("R1 lock_sel reset", {6'b0, lock_sel}, 8'h00);

    cmd1(8'h06);
    rd_status(s);
    chk("R2 enable set", s, 8'h32);
    cmd1(8'h04);
    rd_status(s);
    chk("R2 enable cleared", s, 8'h30);

    for (int v = 0; v < 6; v++) begin
      cmd1(8'h06);
      wr_seq(VEC[v][16:8], 1, VEC[v][7:0], 0);
      if (v == 0) begin
        rd_status(s);
        chk("R7 busy and enable during write", s & 8'h03, 8'h03);
      end
      wait_idle();
    end
    rd_status(s);
    chk("R7 enable cleared after write", s, 8'h30);
    for (int v = 0; v < 6; v++) begin
      rd1(VEC[v][16:8], d);
      chk("R4 table readback", d, VEC[v][7:0]);
    end

    rd_open(9'h1FF);
    xfer(8'h00, d);
    chk("R4 read top address", d, 8'h3C);
    xfer(8'h00, d);
    chk("R4 wrap to zero", d, 8'hA5);
    cs_hi();

    wr_seq(9'h000, 1, 8'hFF, 0);
    waitc(500);
    rd1(9'h000, d);
    chk("R3 write without enable ignored", d, 8'hA5);

    cmd1(8'h06);
    wr_seq(9'h04E, 18, 8'h80, 0);
    wait_idle();
    rd_open(9'h040);
    for (int k = 0; k < 16; k++) begin
      xfer(8'h00, d);
      if (k < 14) chk("R5 page wrap content", d, 8'h82 + 8'(k));
      else chk("R5 page overwrite", d, 8'h90 + 8'(k - 14));
    end
    cs_hi();

    cmd1(8'h06);
    wr_seq(9'h0F0, 1, 8'h99, 3);
    rd_status(s);
    chk("R6 no busy after aborted write", s & 8'h01, 8'h00);
    rd1(9'h0F0, d);
    chk("R6 aborted write dropped", d, 8'h11);
    cmd1(8'h04);

    cmd1(8'h06);
    wr_seq(9'h000, 1, 8'h5E, 0);
    wr_seq(9'h123, 1, 8'hEE, 0);
    wait_idle();
    rd1(9'h123, d);
    chk("R8 write during busy ignored", d, 8'h5A);
    rd1(9'h000, d);
    chk("R8 first write landed", d, 8'h5E);

    prot_on = 1'b1;
    cmd1(8'h06);
    wr_seq(9'h1E4, 8, 8'h40, 0);
    wait_idle();
    prot_on = 1'b0;
    rd_open(9'h1E4);
    for (int k = 0; k < 6; k++) begin
      xfer(8'h00, d);
      if (k < 4) chk("R9 unprotected bytes written", d, 8'h40 + 8'(k));
      else if (k == 5) chk("R9 protected byte kept", d, 8'h77);
    end
    cs_hi();

    cmd1(8'h06);
    cs_lo();
    xfer(8'h01, d);
    xfer(8'h18, d);
    cs_hi();
    chk("R10 lock field held while busy", {6'b0, lock_sel}, 8'h00);
    wait_idle();
    chk("R10 lock_sel updated", {6'b0, lock_sel}, 8'h02);
    chk("R10 wdog_sel updated", {6'b0, wdog_sel}, 8'h01);
    rd_status(s);
    chk("R10 status fields", s, 8'h18);
    cs_lo();
    xfer(8'h01, d);
    xfer(8'h3C, d);
    cs_hi();
    waitc(500);
    rd_status(s);
    chk("R3 status write without enable ignored", s, 8'h18);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule